// File: doc/BRIEF.md
# Receive Mute Frame Detector

This block watches the receive side of a serial audio port and decides when the incoming stream has gone silent for long enough to matter. It takes slot words as the deserializer produces them, together with a strobe that qualifies each slot and a strobe that closes each frame. A frame is treated as silent when none of its qualified slot words carries a nonzero value.

The block counts silent frames that arrive back to back. Any frame with sound in it sets the count back to zero. When the run of silent frames reaches a programmed length, a sticky detection flag goes high. The flag can also drive an interrupt line through an enable. Software clears the flag with a one-cycle pulse.

Detection only runs while the port is in receive mode. Outside that mode, frames are ignored and the run is forgotten.

Top module: `rx_mute_watch`

## Requirements
- R1: After reset, `mute_flag` and `mute_irq` are both 0.
- R2: A frame is silent when every slot word presented with `slot_valid` high is zero. Words presented with `slot_valid` low are ignored. A frame with no qualified slot also counts as silent. The slot that arrives together with `frame_end` belongs to the frame that `frame_end` closes.
- R3: Any frame that holds a nonzero qualified slot word sets the run count to 0.
- R4: When the run of consecutive silent frames reaches `run_limit`, `mute_flag` becomes 1 on the third rising edge, counting the edge that samples `frame_end` as the first.
- R5: Once set, `mute_flag` holds until `flag_clr` is sampled high, and it drops on that edge. If a new detection and a clear occur in the same cycle, the detection wins.
- R6: `mute_irq` is a registered copy of `mute_flag` gated by `irq_en`. It is 0 whenever `irq_en` was 0 at the previous edge.
- R7: A `run_limit` of 0 never sets the flag.
- R8: The run count saturates at 2^CNT_W-1 (63 by default). The flag fires only at the moment the count reaches the limit, so it does not fire again while the same silent run continues after a clear.
- R9: While `rx_mode` is 0, frames are not examined and the run count is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_mode | input | 1 | 1 when the port operates as a receiver |
| slot_valid | input | 1 | Qualifies `slot_data` in this cycle |
| slot_data | input | SLOT_W | Deserialized slot word |
| frame_end | input | 1 | Marks the last cycle of a frame |
| run_limit | input | CNT_W | Number of consecutive silent frames needed to flag |
| irq_en | input | 1 | Lets the flag drive the interrupt line |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| mute_flag | output | 1 | Sticky detection flag |
| mute_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16-bit slots and a 6-bit counter. With these values the counter's ceiling of 63 can be reached in a few thousand cycles, so the test drives the count into saturation, flags at the largest limit, and confirms that the saturated run does not fire again. The default width also puts the limit of 0 in reach, and the bench checks that this case never flags even after the run grows past the ceiling.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  // Frame close event from the tracker to the run counter
  typedef struct packed {
    logic done;    // one frame has just closed
    logic silent;  // that frame held no nonzero qualified word
  } frame_evt_t;
endpackage

// File: rtl/mfd_frame_tracker.sv
module mfd_frame_tracker
  import mfd_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_mode,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot_data,
  input  logic              frame_end,
  output frame_evt_t        evt
);
  logic loud_seen;
  logic slot_loud;

  assign slot_loud = slot_valid && (|slot_data);

  always_ff @(posedge clk) begin
    if (rst || !rx_mode) begin
      loud_seen <= 1'b0;
      evt       <= '0;
    end else begin
      evt.done   <= frame_end;
      evt.silent <= frame_end && !(loud_seen || slot_loud);
      if (frame_end)
        loud_seen <= 1'b0;
      else if (slot_loud)
        loud_seen <= 1'b1;
    end
  end

  // R2: a loud word in the closing cycle marks the frame as not silent
  p_loud_close_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && slot_loud && frame_end) |=> (evt.done && !evt.silent));

  // R9: no frame event leaves the tracker outside receive mode
  p_idle_no_evt_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_mode |=> !evt.done);
endmodule

// File: rtl/mfd_run_counter.sv
module mfd_run_counter
  import mfd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_mode,
  input  frame_evt_t       evt,
  input  logic [CNT_W-1:0] run_limit,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W:0]   run_next;
  logic             grows;

  assign grows    = evt.done && evt.silent && (run_cnt != CNT_MAX);
  assign run_next = {1'b0, run_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !rx_mode) begin
      run_cnt <= '0;
      hit     <= 1'b0;
    end else begin
      hit <= grows && (run_next == {1'b0, run_limit});
      if (evt.done) begin
        if (!evt.silent)
          run_cnt <= '0;
        else if (grows)
          run_cnt <= run_next[CNT_W-1:0];
      end
    end
  end

  // R3: a loud frame sends the run back to zero
  p_loud_resets_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && evt.done && !evt.silent) |=> (run_cnt == '0));

  // R8: the count holds at its ceiling and does not wrap
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && run_cnt == CNT_MAX && evt.done && evt.silent) |=> (run_cnt == CNT_MAX));

  // R7: a zero limit never produces a detection
  p_zero_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (run_limit == '0) |=> !hit);
endmodule

// File: rtl/mfd_flag_unit.sv
module mfd_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic flag_clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_next;

  // a detection takes priority over a clear in the same cycle
  assign flag_next = hit ? 1'b1 : (flag_clr ? 1'b0 : flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_next;
      irq  <= flag_next && irq_en;
    end
  end

  // R5: the flag holds without a clear
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  // R5: a detection is never lost to a simultaneous clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  // R6: no interrupt without the enable
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

// File: rtl/rx_mute_watch.sv
module rx_mute_watch
  import mfd_pkg::*;
#(
  parameter int SLOT_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_mode,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot_data,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  run_limit,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              mute_flag,
  output logic              mute_irq
);
  frame_evt_t evt;
  logic       hit;

  mfd_frame_tracker #(.SLOT_W(SLOT_W)) u_track (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .slot_valid(slot_valid),
    .slot_data(slot_data), .frame_end(frame_end), .evt(evt)
  );

  mfd_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .evt(evt),
    .run_limit(run_limit), .hit(hit)
  );

  mfd_flag_unit u_flag (
    .clk(clk), .rst(rst), .hit(hit), .flag_clr(flag_clr),
    .irq_en(irq_en), .flag(mute_flag), .irq(mute_irq)
  );

  // R1: outputs are low in the cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!mute_flag && !mute_irq));
endmodule

// File: tb/test_rx_mute_watch.sv
module test_rx_mute_watch;
  localparam int SLOT_W = 16;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              rx_mode;
  logic              slot_valid;
  logic [SLOT_W-1:0] slot_data;
  logic              frame_end;
  logic [CNT_W-1:0]  run_limit;
  logic              irq_en;
  logic              flag_clr;
  logic              mute_flag;
  logic              mute_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rx_mute_watch #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) i_rx_mute_watch (
    .clk(clk), .rst(rst), .rx_mode(rx_mode), .slot_valid(slot_valid),
    .slot_data(slot_data), .frame_end(frame_end), .run_limit(run_limit),
    .irq_en(irq_en), .flag_clr(flag_clr), .mute_flag(mute_flag), .mute_irq(mute_irq)
  );

  // vector: {slot0[33:18], slot1[17:2], clear-before[1], expected flag[0]}, limit 3
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h0005, 16'h0000, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b1},
    {16'h0000, 16'h0000, 1'b0, 1'b1},
    {16'h0000, 16'h0000, 1'b1, 1'b0},
    {16'h0000, 16'h0001, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0},
    {16'h8000, 16'h0000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_frame(input logic [15:0] a, input logic [15:0] b,
                            input logic va, input logic vb);
    @(negedge clk);
    slot_valid = va; slot_data = a; frame_end = 1'b0;
    @(negedge clk);
    slot_valid = vb; slot_data = b; frame_end = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0; slot_data = '0; frame_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_mode = 1'b1; slot_valid = 1'b0; slot_data = '0;
    frame_end = 1'b0; run_limit = 6'd3; irq_en = 1'b1; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 flag", mute_flag, 1'b0);
    check("R1 irq", mute_irq, 1'b0);
    rst = 1'b0;

    // table walk: R2 R3 R4 R5 R6 with limit 3
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][1]) pulse_clear();
      send_frame(VEC[i][33:18], VEC[i][17:2], 1'b1, 1'b1);
      check("R4 table flag", mute_flag, VEC[i][0]);
      check("R6 table irq", mute_irq, VEC[i][0]);
    end

    // R4 exact latency: flag appears on the third edge after frame_end is sampled
    do_reset();
    run_limit = 6'd1;
    @(negedge clk);
    slot_valid = 1'b1; slot_data = '0; frame_end = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0; frame_end = 1'b0;
    @(negedge clk);
    check("R4 not yet", mute_flag, 1'b0);
    @(negedge clk);
    check("R4 latency", mute_flag, 1'b1);

    // R2: nonzero words with slot_valid low are ignored; empty frame is silent
    do_reset();
    run_limit = 6'd2;
    send_frame(16'hFFFF, 16'h1234, 1'b0, 1'b0);
    check("R2 one frame", mute_flag, 1'b0);
    send_frame(16'h0000, 16'h00AA, 1'b1, 1'b0);
    check("R2 invalid ignored", mute_flag, 1'b1);

    // R6: enable off keeps irq low while the flag is set
    do_reset();
    irq_en = 1'b0; run_limit = 6'd1;
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R6 flag", mute_flag, 1'b1);
    check("R6 irq gated", mute_irq, 1'b0);
    irq_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 irq follows", mute_irq, 1'b1);
    pulse_clear();
    check("R5 cleared", mute_flag, 1'b0);

    // R5: detection wins over a simultaneous clear
    do_reset();
    run_limit = 6'd1;
    @(negedge clk);
    slot_valid = 1'b1; slot_data = '0; frame_end = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0; frame_end = 1'b0;
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R5 set wins", mute_flag, 1'b1);

    // R9: receive mode off ignores frames and forgets the run
    do_reset();
    run_limit = 6'd2;
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    rx_mode = 1'b0;
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R9 idle no flag", mute_flag, 1'b0);
    rx_mode = 1'b1;
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R9 run forgotten", mute_flag, 1'b0);
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R9 fresh run", mute_flag, 1'b1);

    // R7: zero limit never flags, even past the ceiling
    do_reset();
    run_limit = 6'd0;
    for (int k = 0; k < 70; k++) send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R7 zero limit", mute_flag, 1'b0);

    // R8: limit 63 reached, then saturated run does not fire again
    do_reset();
    run_limit = 6'd63;
    for (int k = 0; k < 62; k++) send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R8 below ceiling", mute_flag, 1'b0);
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R8 at ceiling", mute_flag, 1'b1);
    pulse_clear();
    for (int k = 0; k < 10; k++) send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R8 no retrigger", mute_flag, 1'b0);
    check("R3 loud restart pre", mute_flag, 1'b0);
    run_limit = 6'd1;
    send_frame(16'h0001, 16'h0000, 1'b1, 1'b1);
    check("R3 loud frame", mute_flag, 1'b0);
    send_frame(16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R3 restarted run", mute_flag, 1'b1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule